// File: doc/BRIEF.md
# Guarded Scaled-Index Word Load Unit

This unit carries out a 32-bit load whose byte address is a base operand plus four times an index operand. The sum wraps modulo 2^32. The unit reads one aligned word from a byte-addressed data memory. It puts the four bytes in order according to an endianness mode bit that it samples when the operation issues. It then returns the word on a register write-back port, together with the destination tag that travelled with the operation.

An optional guard decides whether the load has any effect. Only the guard's least significant bit counts. A cleared bit suppresses the memory read and the write-back. An operation with no guard behaves as if the bit were set.

The unit is fully pipelined and accepts one operation per cycle. A result appears at the write-back port exactly three cycles after its operation is presented. If the address is not a multiple of four, the unit raises no error and returns zero.

Top module: `scaled_load_unit`

## Requirements
- R1: The effective address is op_base + 4*op_index, computed modulo 2^32. In the cycle after an allowed operation is presented, mem_rd_en is 1 and mem_rd_addr holds the effective address with its two low bits cleared.
- R2: An operation with op_guard_en=1 and op_guard[0]=0 produces no memory read (mem_rd_en stays 0) and no write-back (wb_en stays 0).
- R3: An operation with op_guard_en=0 is performed as if the guard bit were 1. Bits 31:1 of op_guard have no effect: a guard of 0x2 suppresses the operation and a guard of 0xFFFFFFFF allows it.
- R4: With big_endian=0, wb_data bits 8k+7:8k hold the memory byte at address A+k, for k = 0..3, where A is the aligned effective address.
- R5: With big_endian=1, wb_data bits 31:24 hold the byte at A, bits 23:16 the byte at A+1, bits 15:8 the byte at A+2 and bits 7:0 the byte at A+3.
- R6: An allowed operation presented in cycle c raises wb_en in cycle c+3, with wb_dest equal to its op_dest. Back-to-back operations each return their own tag and data in issue order.
- R7: When the effective address is not a multiple of 4, wb_data is 0x00000000. wb_en still follows the guard.
- R8: A synchronous active-high rst discards every operation in flight. No write-back occurs in the cycles after reset, and wb_en and mem_rd_en are 0 while rst is held.
- R9: The endianness applied to an operation is the value of big_endian in the cycle that operation is presented. Later changes to big_endian do not affect it.
- R10: A cycle with op_valid=0 causes no memory read and no write-back, whatever the other operand inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_base | input | 32 | Base operand |
| op_index | input | 32 | Index operand, scaled by 4 |
| op_guard | input | 32 | Guard value; only bit 0 is used |
| op_guard_en | input | 1 | Guard present |
| op_dest | input | TAG_W | Destination register tag |
| big_endian | input | 1 | Byte order mode, 1 = big-endian |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Word-aligned byte address of the read |
| mem_rd_data | input | 32 | Read data one cycle after the request; byte k is the byte at address+k |
| wb_en | output | 1 | Write-back enable |
| wb_dest | output | TAG_W | Write-back destination tag |
| wb_data | output | 32 | Loaded word |

## Verification
The hardest cases to reach are several operations in flight at once, each carrying its own guard, endianness and tag. Two related cases are hard in the same way: a mode change or a reset that lands while an earlier operation is still in the pipeline. The bench therefore issues its vector table back to back, one operation per cycle, mixing guard states, byte orders and tags. It checks each result three cycles later, so a tag or mode that leaks between stages shows up as a mismatch. Directed sequences then flip big_endian and assert rst in the cycle right after an issue, and check that the in-flight operation keeps its sampled mode or vanishes.

// File: rtl/slu_pkg.sv
package slu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = WORD_W / LANE_W;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OFF_W-1:0]  off_t;

  // base + index scaled by the word size, modulo 2^WORD_W
  function automatic word_t eff_addr(word_t base, word_t index);
    return base + (index << OFF_W);
  endfunction

  // XOR key for byte reordering: all ones for little-endian, zero for big-endian
  function automatic off_t swap_key(logic big);
    return big ? '0 : '1;
  endfunction

  // memory byte offset feeding result lane `lane`
  function automatic off_t lane_src(int unsigned lane, off_t key);
    off_t rev;
    rev = off_t'(LANES - 1 - lane);
    return rev ^ key;
  endfunction

  function automatic logic guard_pass(logic present, logic lsb);
    return !present || lsb;
  endfunction
endpackage

// File: rtl/slu_agen.sv
module slu_agen
  import slu_pkg::*;
#(
  parameter int unsigned TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  word_t            op_base,
  input  word_t            op_index,
  input  word_t            op_guard,
  input  logic             op_guard_en,
  input  logic [TAG_W-1:0] op_dest,
  input  logic             big_endian,
  output logic             s1_valid,
  output word_t            s1_waddr,
  output logic [TAG_W-1:0] s1_dest,
  output off_t             s1_key,
  output logic             s1_misal
);
  word_t ea;
  logic  pass;
  logic  issue;
  logic  unused_guard_hi;

  assign ea              = eff_addr(op_base, op_index);
  assign pass            = guard_pass(op_guard_en, op_guard[0]);
  assign issue           = op_valid && pass;
  assign unused_guard_hi = ^op_guard[WORD_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= issue;
    s1_waddr <= {ea[WORD_W-1:OFF_W], {OFF_W{1'b0}}};
    s1_misal <= |ea[OFF_W-1:0];
    s1_dest  <= op_dest;
    s1_key   <= swap_key(big_endian);
  end

  p_guard_block_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_guard_en && !op_guard[0]) |=> !s1_valid);
  p_noguard_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_guard_en) |=> s1_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !s1_valid);
endmodule

// File: rtl/slu_byte_order.sv
module slu_byte_order
  import slu_pkg::*;
(
  input  word_t raw,
  input  off_t  key,
  input  logic  misal,
  output word_t ordered
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    off_t src;
    assign src = lane_src(j, key);
    assign ordered[j*LANE_W +: LANE_W] =
      misal ? '0 : raw[32'(src)*LANE_W +: LANE_W];
  end

  always_comb begin
    if (misal) p_misal_zero_r7: assert (ordered == '0);
  end
endmodule

// File: rtl/scaled_load_unit.sv
module scaled_load_unit
  import slu_pkg::*;
#(
  parameter int unsigned TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [31:0]      op_base,
  input  logic [31:0]      op_index,
  input  logic [31:0]      op_guard,
  input  logic             op_guard_en,
  input  logic [TAG_W-1:0] op_dest,
  input  logic             big_endian,
  output logic             mem_rd_en,
  output logic [31:0]      mem_rd_addr,
  input  logic [31:0]      mem_rd_data,
  output logic             wb_en,
  output logic [TAG_W-1:0] wb_dest,
  output logic [31:0]      wb_data
);
  logic             s1_valid;
  word_t            s1_waddr;
  logic [TAG_W-1:0] s1_dest;
  off_t             s1_key;
  logic             s1_misal;

  logic             s2_valid;
  logic [TAG_W-1:0] s2_dest;
  off_t             s2_key;
  logic             s2_misal;
  word_t            ordered;

  slu_agen #(.TAG_W(TAG_W)) u_agen (
    .clk(clk), .rst(rst), .op_valid(op_valid),
    .op_base(op_base), .op_index(op_index), .op_guard(op_guard),
    .op_guard_en(op_guard_en), .op_dest(op_dest), .big_endian(big_endian),
    .s1_valid(s1_valid), .s1_waddr(s1_waddr), .s1_dest(s1_dest),
    .s1_key(s1_key), .s1_misal(s1_misal)
  );

  assign mem_rd_en   = s1_valid;
  assign mem_rd_addr = s1_waddr;

  // stage 2: metadata waits alongside the memory access
  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
    s2_dest  <= s1_dest;
    s2_key   <= s1_key;
    s2_misal <= s1_misal;
  end

  slu_byte_order u_order (
    .raw(mem_rd_data), .key(s2_key), .misal(s2_misal), .ordered(ordered)
  );

  // stage 3: write-back register
  always_ff @(posedge clk) begin
    if (rst) wb_en <= 1'b0;
    else     wb_en <= s2_valid;
    wb_dest <= s2_dest;
    wb_data <= ordered;
  end

  p_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00));
  p_wb_follows_r6: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> $past(mem_rd_en, 2));
  p_tag_carried_r6: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_dest == $past(s1_dest, 2)));
  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> (!wb_en && !mem_rd_en));
endmodule

// File: tb/scaled_load_unit_tb.sv
module scaled_load_unit_tb;
  localparam int TAG_W = 5;

  typedef struct packed {
    logic [23:0] req;
    logic [31:0] base;
    logic [31:0] index;
    logic [31:0] guard;
    logic        gen;
    logic        big;
    logic        exp_en;
    logic [31:0] exp_data;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{"R5 ", 32'h00000cfc, 32'h00000001, 32'h0,        1'b0, 1'b1, 1'b1, 32'h84332211},
    '{"R2 ", 32'h00000d0c, 32'hfffffffe, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0},
    '{"R1 ", 32'h00000d0c, 32'hfffffffe, 32'h1,        1'b1, 1'b1, 1'b1, 32'h48665544},
    '{"R4 ", 32'h00000d00, 32'h00000000, 32'h0,        1'b0, 1'b0, 1'b1, 32'h11223384},
    '{"R4 ", 32'h00000100, 32'h00000000, 32'h0,        1'b0, 1'b0, 1'b1, 32'h3f3e3d3c},
    '{"R5 ", 32'h00000100, 32'h00000000, 32'h0,        1'b0, 1'b1, 1'b1, 32'h3c3d3e3f},
    '{"R7 ", 32'h00000d01, 32'h00000001, 32'h0,        1'b0, 1'b1, 1'b1, 32'h0},
    '{"R3 ", 32'h00000100, 32'h00000000, 32'h2,        1'b1, 1'b0, 1'b0, 32'h0},
    '{"R3 ", 32'h00000200, 32'h00000003, 32'hffffffff, 1'b1, 1'b0, 1'b1, 32'h33323130},
    '{"R1 ", 32'hfffffff0, 32'h00000008, 32'h0,        1'b0, 1'b1, 1'b1, 32'h2c2d2e2f},
    '{"R7 ", 32'h00000102, 32'h00000000, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             op_valid = 1'b0;
  logic [31:0]      op_base = '0, op_index = '0, op_guard = '0;
  logic             op_guard_en = 1'b0;
  logic [TAG_W-1:0] op_dest = '0;
  logic             big_endian = 1'b0;
  logic             mem_rd_en;
  logic [31:0]      mem_rd_addr;
  logic [31:0]      mem_rd_data = '0;
  logic             wb_en;
  logic [TAG_W-1:0] wb_dest;
  logic [31:0]      wb_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scaled_load_unit #(.TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_base(op_base),
    .op_index(op_index), .op_guard(op_guard), .op_guard_en(op_guard_en),
    .op_dest(op_dest), .big_endian(big_endian), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .wb_en(wb_en),
    .wb_dest(wb_dest), .wb_data(wb_data)
  );

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    case (a)
      32'hd00: return 8'h84;
      32'hd01: return 8'h33;
      32'hd02: return 8'h22;
      32'hd03: return 8'h11;
      32'hd04: return 8'h48;
      32'hd05: return 8'h66;
      32'hd06: return 8'h55;
      32'hd07: return 8'h44;
      default: return a[7:0] ^ 8'h3c;
    endcase
  endfunction

  always @(posedge clk)
    if (mem_rd_en)
      mem_rd_data <= {mem_byte(mem_rd_addr + 32'd3), mem_byte(mem_rd_addr + 32'd2),
                      mem_byte(mem_rd_addr + 32'd1), mem_byte(mem_rd_addr)};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] b, input logic [31:0] i,
                       input logic [31:0] g, input logic ge, input logic be,
                       input logic [TAG_W-1:0] t);
    op_valid = v; op_base = b; op_index = i; op_guard = g;
    op_guard_en = ge; big_endian = be; op_dest = t;
  endtask

  task automatic idle();
    drive(1'b0, '0, '0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R6 watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: quiet while reset held
    chk("R8 reset wb_en", 32'(wb_en), 32'h0);
    chk("R8 reset mem_rd_en", 32'(mem_rd_en), 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // table, issued back to back (R6)
    for (int k = 0; k < NV + 3; k++) begin
      if (k >= 1 && k - 1 < NV) begin
        chk({VT[k-1].req, " rd_en"}, 32'(mem_rd_en), 32'(VT[k-1].exp_en));
        if (VT[k-1].exp_en)
          chk("R1 rd_addr", mem_rd_addr,
              (VT[k-1].base + VT[k-1].index * 32'd4) & 32'hffff_fffc);
      end
      if (k >= 3) begin
        chk({VT[k-3].req, " wb_en"}, 32'(wb_en), 32'(VT[k-3].exp_en));
        if (VT[k-3].exp_en) begin
          chk("R6 wb_dest", 32'(wb_dest), k - 3);
          chk({VT[k-3].req, " wb_data"}, wb_data, VT[k-3].exp_data);
        end
      end
      if (k < NV)
        drive(1'b1, VT[k].base, VT[k].index, VT[k].guard, VT[k].gen, VT[k].big,
              TAG_W'(k));
      else
        idle();
      @(negedge clk);
    end

    // R9: mode flipped right after issue
    drive(1'b1, 32'hd00, 32'h0, 32'h0, 1'b0, 1'b1, 5'd20);
    @(negedge clk);
    drive(1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 5'd0);
    repeat (2) @(negedge clk);
    chk("R9 wb_en", 32'(wb_en), 32'h1);
    chk("R9 wb_data", wb_data, 32'h84332211);
    chk("R9 wb_dest", 32'(wb_dest), 32'd20);
    @(negedge clk);

    // R10: op_valid low with busy operand fields
    drive(1'b0, 32'h100, 32'h4, 32'h1, 1'b1, 1'b1, 5'd9);
    @(negedge clk);
    idle();
    chk("R10 rd_en", 32'(mem_rd_en), 32'h0);
    repeat (2) @(negedge clk);
    chk("R10 wb_en", 32'(wb_en), 32'h0);

    // R8: reset right after an issue discards it
    drive(1'b1, 32'h100, 32'h0, 32'h0, 1'b0, 1'b0, 5'd7);
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 rd_en after reset", 32'(mem_rd_en), 32'h0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R8 wb_en after reset", 32'(wb_en), 32'h0);
    end

    // R6: unit still works after reset
    drive(1'b1, 32'h100, 32'h0, 32'h0, 1'b0, 1'b1, 5'd3);
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    chk("R6 wb_en post-reset", 32'(wb_en), 32'h1);
    chk("R5 wb_data post-reset", wb_data, 32'h3c3d3e3f);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule